// File: doc/BRIEF.md
# Correlated Stochastic Bit-Stream Pair Generator

This block emits two unipolar stochastic bit streams side by side, one bit of each per clock, over a fixed frame of 1024 cycles. The first stream (X) has a programmed probability of ones. The second stream (Y) has its own programmed probability of ones and a chosen bit-level correlation with X. Software supplies P(X=1), P(Y=1) and the joint probability P(X=1 and Y=1) as 12-bit binary fractions (value / 4096). The joint probability fixes the correlation coefficient.

After a start pulse the block latches its configuration and loads two seeds into two 12-bit LFSRs that step together. Two sequential restoring dividers compute the conditional probabilities P(Y=1|X=1) and P(Y=1|X=0). The frame then runs. X is set when the first LFSR value is below P(X=1). Y is set when the second LFSR value is below the conditional threshold that the current X bit selects. This two-level decision is what imposes the correlation.

The block counts the ones in X, in Y and in X AND Y. It presents those counts at the end of the frame, together with a one-cycle done pulse.

Top module: `corr_stream_gen`

## Requirements
- R1: While reset is high, and after it falls until the first start, valid, done, both stream bits and all three counts are 0.
- R2: On start the block computes thresholds q1 = min(4095, floor(p11*4096/px)), with q1 = 0 when px = 0, and q0 = min(4095, floor(n0*4096/(4096-px))), where n0 = py-p11 when py >= p11 and 0 otherwise.
- R3: In each valid cycle x is 1 exactly when the current state of LFSR A is below the px latched at start.
- R4: In each valid cycle y is 1 exactly when the current state of LFSR B is below q1 if that cycle's x is 1, and below q0 otherwise.
- R5: On start each LFSR loads its seed, and a seed of 0 is replaced by 1. Each valid cycle uses the current states and then advances both LFSRs to {s[10:0], s[11]^s[10]^s[9]^s[3]}.
- R6: After thresholds are ready, valid is high for exactly 1024 consecutive cycles, and it rises within 20 cycles of start.
- R7: done is high for exactly one cycle, the cycle right after the last valid cycle, and is never high together with valid.
- R8: When done is high, the three 11-bit counts equal the number of ones in x, in y and in x AND y over the frame.
- R9: While a frame is in progress, start and changes on the configuration inputs have no effect on the streams, the frame length or the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (accepted only while idle) |
| px_i | input | 12 | P(X=1) as a fraction of 4096 |
| py_i | input | 12 | P(Y=1) as a fraction of 4096 |
| p11_i | input | 12 | P(X=1, Y=1) as a fraction of 4096 |
| seed_a_i | input | 12 | Seed for the X random source |
| seed_b_i | input | 12 | Seed for the Y random source |
| x_o | output | 1 | Stream X bit |
| y_o | output | 1 | Stream Y bit |
| valid_o | output | 1 | x_o and y_o hold a frame bit |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| ones_x_o | output | 11 | Count of ones in X |
| ones_y_o | output | 11 | Count of ones in Y |
| ones_xy_o | output | 11 | Count of cycles with X and Y both 1 |

## Verification
The divider remainder check assumes that each divide starts with a numerator below a nonzero divisor. The divider itself routes a zero divisor or a numerator that is too large to a flagged path, so every input combination stays inside that assumption, including p11 above py or infeasible triples. The random stimulus draws p11 inside the feasible joint range for its px and py. The directed cases push on the edges: px at 0 and 4095, zero seeds, a numerator that saturates, and a start pulse with new configuration values in the middle of a frame.

// File: rtl/csg_pkg.sv
package csg_pkg;

    localparam int PROB_W    = 12;
    localparam int FRAME_LEN = 1024;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int IDX_W     = $clog2(FRAME_LEN);

    typedef logic [PROB_W-1:0] prob_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIN  = 2'd3
    } gen_state_t;

    typedef struct packed {
        prob_t px;
        prob_t py;
        prob_t p11;
    } gen_cfg_t;

    typedef struct packed {
        cnt_t x;
        cnt_t y;
        cnt_t xy;
    } ones_cnt_t;

    // Feedback polynomial x^12 + x^11 + x^10 + x^4 + 1.
    function automatic prob_t lfsr_advance(input prob_t s);
        return {s[10:0], s[11] ^ s[10] ^ s[9] ^ s[3]};
    endfunction

    function automatic prob_t nonzero_seed(input prob_t s);
        return (s == '0) ? prob_t'(1) : s;
    endfunction

endpackage

// File: rtl/csg_lfsr.sv
module csg_lfsr
    import csg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  prob_t seed,
    input  logic  step,
    output prob_t value
);

    prob_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= prob_t'(1);
        end else if (load) begin
            st_q <= nonzero_seed(seed);
        end else if (step) begin
            st_q <= lfsr_advance(st_q);
        end
    end

    assign value = st_q;

    // R5: the register never reaches the lock-up state
    a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);

endmodule

// File: rtl/csg_div.sv
module csg_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W:0]   num,
    input  logic [W:0]   den,
    output logic [W-1:0] quo,
    output logic         ready
);

    localparam int IW = $clog2(W + 1);

    logic [W+1:0] rem_q;
    logic [W:0]   den_q;
    logic [W-1:0] q_q;
    logic [IW-1:0] it_q;
    logic busy_q, have_q, sat_q, zero_q;
    logic [W+1:0] shifted;
    logic         fits;

    assign shifted = {rem_q[W:0], 1'b0};
    assign fits    = shifted >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            den_q  <= '0;
            q_q    <= '0;
            it_q   <= '0;
            busy_q <= 1'b0;
            have_q <= 1'b0;
            sat_q  <= 1'b0;
            zero_q <= 1'b0;
        end else if (load) begin
            rem_q  <= {1'b0, num};
            den_q  <= den;
            q_q    <= '0;
            it_q   <= '0;
            busy_q <= 1'b1;
            have_q <= 1'b0;
            zero_q <= (den == '0);
            sat_q  <= (den != '0) && (num >= den);
        end else if (busy_q) begin
            rem_q <= fits ? (shifted - {1'b0, den_q}) : shifted;
            q_q   <= {q_q[W-2:0], fits};
            it_q  <= it_q + 1'b1;
            if (it_q == IW'(W - 1)) begin
                busy_q <= 1'b0;
                have_q <= 1'b1;
            end
        end
    end

    assign quo   = zero_q ? '0 : (sat_q ? '1 : q_q);
    assign ready = have_q && !busy_q;

    // R2: restoring invariant, remainder stays below the divisor
    a_r2_rem_below_den: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !sat_q && !zero_q) |-> (rem_q < {1'b0, den_q}));

    // R2: the iteration count never runs past the quotient width
    a_r2_iter_bound: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (it_q < IW'(W)));

endmodule

// File: rtl/corr_stream_gen.sv
module corr_stream_gen
    import csg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [11:0] px_i,
    input  logic [11:0] py_i,
    input  logic [11:0] p11_i,
    input  logic [11:0] seed_a_i,
    input  logic [11:0] seed_b_i,
    output logic        x_o,
    output logic        y_o,
    output logic        valid_o,
    output logic        done_o,
    output logic [10:0] ones_x_o,
    output logic [10:0] ones_y_o,
    output logic [10:0] ones_xy_o
);

    localparam int NDIV = 2;

    gen_state_t st_q;
    gen_cfg_t   cfg;
    prob_t      px_q;
    ones_cnt_t  cnt_q;
    logic [IDX_W-1:0] idx_q;

    logic accept, step;
    prob_t rnd_a, rnd_b;
    logic [PROB_W:0] div_num [NDIV];
    logic [PROB_W:0] div_den [NDIV];
    prob_t           div_quo [NDIV];
    logic [NDIV-1:0] div_rdy;
    logic xb, yb;
    prob_t thr;

    assign cfg    = '{px: px_i, py: py_i, p11: p11_i};
    assign accept = (st_q == ST_IDLE) && start;
    assign step   = (st_q == ST_RUN);

    // Index 1: threshold given X=1; index 0: threshold given X=0.
    assign div_num[1] = {1'b0, cfg.p11};
    assign div_den[1] = {1'b0, cfg.px};
    assign div_num[0] = (cfg.py >= cfg.p11) ? {1'b0, cfg.py - cfg.p11} : '0;
    assign div_den[0] = (PROB_W+1)'(1 << PROB_W) - {1'b0, cfg.px};

    generate
        for (genvar g = 0; g < NDIV; g++) begin : g_div
            csg_div #(.W(PROB_W)) u_div (
                .clk   (clk),
                .rst   (rst),
                .load  (accept),
                .num   (div_num[g]),
                .den   (div_den[g]),
                .quo   (div_quo[g]),
                .ready (div_rdy[g])
            );
        end
    endgenerate

    csg_lfsr u_src_a (
        .clk(clk), .rst(rst), .load(accept), .seed(seed_a_i),
        .step(step), .value(rnd_a)
    );

    csg_lfsr u_src_b (
        .clk(clk), .rst(rst), .load(accept), .seed(seed_b_i),
        .step(step), .value(rnd_b)
    );

    assign xb  = rnd_a < px_q;
    assign thr = xb ? div_quo[1] : div_quo[0];
    assign yb  = rnd_b < thr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            px_q    <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            x_o     <= 1'b0;
            y_o     <= 1'b0;
            valid_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    done_o <= 1'b0;
                    if (start) begin
                        st_q  <= ST_DIV;
                        px_q  <= cfg.px;
                        cnt_q <= '0;
                    end
                end
                ST_DIV: begin
                    if (&div_rdy) begin
                        st_q  <= ST_RUN;
                        idx_q <= '0;
                    end
                end
                ST_RUN: begin
                    x_o      <= xb;
                    y_o      <= yb;
                    valid_o  <= 1'b1;
                    cnt_q.x  <= cnt_q.x + cnt_t'(xb);
                    cnt_q.y  <= cnt_q.y + cnt_t'(yb);
                    cnt_q.xy <= cnt_q.xy + cnt_t'(xb & yb);
                    idx_q    <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(FRAME_LEN - 1)) st_q <= ST_FIN;
                end
                ST_FIN: begin
                    valid_o <= 1'b0;
                    done_o  <= 1'b1;
                    st_q    <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ones_x_o  = cnt_q.x;
    assign ones_y_o  = cnt_q.y;
    assign ones_xy_o = cnt_q.xy;

    // R7: done and valid never overlap
    a_r7_done_excl_valid: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !valid_o);

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: a frame only ends through done
    a_r6_end_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(valid_o) |-> done_o);

    // R2: both dividers finish together
    a_r2_div_lockstep: assert property (@(posedge clk) disable iff (rst)
        $countones(div_rdy) != 1);

    // R8: the joint count never exceeds either marginal count
    a_r8_joint_bound: assert property (@(posedge clk) disable iff (rst)
        (ones_xy_o <= ones_x_o) && (ones_xy_o <= ones_y_o));

    // R9: start during a frame does not break the run
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (valid_o && start) |=> (valid_o || done_o));

endmodule

// File: tb/sim_corr_stream_gen.sv
module sim_corr_stream_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] px_i = '0, py_i = '0, p11_i = '0, seed_a_i = '0, seed_b_i = '0;
    logic        x_o, y_o, valid_o, done_o;
    logic [10:0] ones_x_o, ones_y_o, ones_xy_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    corr_stream_gen u0 (
        .clk(clk), .rst(rst), .start(start),
        .px_i(px_i), .py_i(py_i), .p11_i(p11_i),
        .seed_a_i(seed_a_i), .seed_b_i(seed_b_i),
        .x_o(x_o), .y_o(y_o), .valid_o(valid_o), .done_o(done_o),
        .ones_x_o(ones_x_o), .ones_y_o(ones_y_o), .ones_xy_o(ones_xy_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lfsr_nx(input int s);
        return ((s << 1) & 12'hFFF) | (((s >> 11) ^ (s >> 10) ^ (s >> 9) ^ (s >> 3)) & 1);
    endfunction

    function automatic int div_q(input int num, input int den);
        if (den == 0) return 0;
        if (num >= den) return 4095;
        return (num * 4096) / den;
    endfunction

    task automatic run_frame(input int px, input int py, input int p11,
                             input int sa, input int sb, input bit midstart);
        int q1, q0, ra, rb, nv, bad, cx, cy, cxy, wt, first_act, first_exp;
        bit ex, ey;
        q1 = div_q(p11, px);
        q0 = div_q((py >= p11) ? py - p11 : 0, 4096 - px);
        ra = (sa == 0) ? 1 : sa;
        rb = (sb == 0) ? 1 : sb;
        @(negedge clk);
        px_i = px[11:0]; py_i = py[11:0]; p11_i = p11[11:0];
        seed_a_i = sa[11:0]; seed_b_i = sb[11:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wt = 1;
        while (!valid_o && wt < 20) begin
            @(negedge clk);
            wt++;
        end
        check(valid_o === 1'b1, "R6 valid rises within 20 cycles", wt, 20);
        nv = 0; bad = 0; cx = 0; cy = 0; cxy = 0; first_act = 0; first_exp = 0;
        while (valid_o === 1'b1 && nv < 2000) begin
            ex = (ra < px);
            ey = (rb < (ex ? q1 : q0));
            if (x_o !== ex || y_o !== ey) begin
                if (bad == 0) begin
                    first_act = {x_o, y_o};
                    first_exp = {ex, ey};
                end
                bad++;
            end
            cx += ex; cy += ey; cxy += (ex & ey);
            ra = lfsr_nx(ra);
            rb = lfsr_nx(rb);
            nv++;
            if (midstart && nv == 500) begin
                start = 1'b1;
                px_i = ~px_i; py_i = ~py_i; p11_i = 12'h000;
                seed_a_i = 12'h0F0; seed_b_i = 12'h00F;
            end
            if (midstart && nv == 501) start = 1'b0;
            @(negedge clk);
        end
        check(bad == 0, midstart ? "R9 R3 R4 R5 bits with start mid-frame"
                                 : "R3 R4 R5 stream bits (first mismatch {x,y})",
              first_act, first_exp);
        check(nv == 1024, "R6 valid length", nv, 1024);
        check(done_o === 1'b1, "R7 done after last valid", done_o, 1);
        check(ones_x_o == cx, "R8 ones in x", ones_x_o, cx);
        check(ones_y_o == cy, "R8 ones in y", ones_y_o, cy);
        check(ones_xy_o == cxy, "R8 ones in x and y", ones_xy_o, cxy);
        @(negedge clk);
        check(done_o === 1'b0 && valid_o === 1'b0, "R7 done single cycle, R9 no restart",
              {done_o, valid_o}, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int px, py, p11, lo, hi, dummy;
        dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(valid_o === 0 && done_o === 0 && x_o === 0 && y_o === 0,
              "R1 outputs in reset", {valid_o, done_o, x_o, y_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(ones_x_o == 0 && ones_y_o == 0 && ones_xy_o == 0 && valid_o === 0,
              "R1 idle after reset", ones_x_o + ones_y_o + ones_xy_o, 0);

        // Directed corners
        run_frame(0, 2048, 0, 12'h5A5, 12'h3C3, 0);       // R2 px = 0, q1 forced 0
        run_frame(4095, 4095, 4095, 12'h001, 12'h800, 0); // R2 saturation at top
        run_frame(2048, 1024, 0, 0, 0, 0);                // R5 zero seeds
        run_frame(1000, 3900, 600, 12'h123, 12'h456, 0);  // R2 q0 saturates
        run_frame(3000, 500, 900, 12'h777, 12'h111, 0);   // R2 p11 above py, n0 = 0
        run_frame(1500, 2500, 1000, 12'hABC, 12'h321, 1); // R9 start mid-frame

        // Feasible random configurations
        for (int k = 0; k < 5; k++) begin
            px  = $urandom % 4096;
            py  = $urandom % 4096;
            lo  = (px + py > 4096) ? px + py - 4096 : 0;
            hi  = (px < py) ? px : py;
            p11 = lo + ($urandom % (hi - lo + 1));
            run_frame(px, py, p11, $urandom % 4096, $urandom % 4096, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule